// File: doc/BRIEF.md
# Receive Queue Idle-Character Timeout Detector

This block sits beside a UART receive queue and reports stale data. It counts character-time ticks while characters are waiting in the queue. When the most recently received character has waited longer than a programmable number of character times, with no queue traffic in between, it raises a status flag. A separate enable bit decides whether that flag is also driven onto an interrupt request line.

Any push into the queue or pop from it restarts the count. An empty queue holds the count at zero. A programmed limit of zero switches detection off. The queue, the receiver, the baud timing and the register decode live outside this block. The block sees only strobes, the empty indication, the limit value, the tick and the enable bit.

Top module: `rx_stale_timer`

## Requirements
- R1: While the queue is non-empty and neither `fifo_push` nor `fifo_pop` is high, every clock edge with `char_tick` high adds one to an internal count that starts at zero. `stale_flag` goes high on the edge at which the count first becomes greater than `tmo_value`, which is the (T+1)-th tick after a restart for a limit T.
- R2: A clock edge with `fifo_pop` high resets the count to zero and clears `stale_flag` on that edge.
- R3: A clock edge with `fifo_push` high resets the count to zero and clears `stale_flag` on that edge.
- R4: `fifo_push` and `fifo_pop` high in the same cycle give exactly one restart, the same as either strobe alone.
- R5: While `fifo_empty` is high, the count is held at zero and `stale_flag` is low after that edge, even if `char_tick` is high.
- R6: With `tmo_value` equal to zero, `stale_flag` is low after every clock edge, and a flag that was already set is cleared on the first edge with the zero limit.
- R7: `stale_irq` is high exactly when `stale_flag` is high and `irq_en` is high. With `irq_en` low the flag is still visible.
- R8: Once set, `stale_flag` stays high on every later edge that has no push, no pop, a non-empty queue and a non-zero limit, whether or not ticks arrive and even if `tmo_value` is raised above the count.
- R9: A new `tmo_value` is used from the next clock edge. Lowering it below the current count sets `stale_flag` on that edge without needing a tick.
- R10: A synchronous active-high `rst` clears the count, `stale_flag` and `stale_irq` on the edge at which it is sampled.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| fifo_push | input | 1 | A character was written into the receive queue this cycle |
| fifo_pop | input | 1 | A character was read from the receive queue this cycle |
| fifo_empty | input | 1 | Receive queue holds no characters |
| tmo_value | input | TMO_W (8) | Timeout limit in character times; zero disables detection |
| char_tick | input | 1 | One-cycle pulse per character time |
| irq_en | input | 1 | Routes the stale flag to the interrupt request |
| stale_flag | output | 1 | Stale-data status |
| stale_irq | output | 1 | Masked interrupt request |

## Verification
The checker confirms on every cycle that the flag is low after any edge with a restart, an empty queue or a zero limit. It also confirms that a set flag persists when nothing clears it, that the interrupt never appears without both the flag and the enable, and that reset clears both outputs. Only the bench scenarios can show the exact tick on which the flag rises for each limit, including the largest one. They also show that a lowered limit takes effect immediately and that push, pop and both together all give an identical restart. The bench sweeps limits 0 to 5 and 255 with the enable both low and high, and compares every cycle against an arithmetic model of the count.

// File: rtl/rx_stale_pkg.sv
package rx_stale_pkg;
   typedef enum logic [1:0] {
      CNT_HOLD  = 2'd0,
      CNT_STEP  = 2'd1,
      CNT_CLEAR = 2'd2
   } cnt_act_e;
endpackage

// File: rtl/rx_stale_ctl.sv
module rx_stale_ctl
   import rx_stale_pkg::*;
#(
   parameter int TMO_W = 8
) (
   input  logic             push,
   input  logic             pop,
   input  logic             empty,
   input  logic             tick,
   input  logic [TMO_W-1:0] tmo,
   output cnt_act_e         act,
   output logic             disarm
);
   logic restart;

   always_comb begin
      restart = push | pop;
      if (restart || empty)
         act = CNT_CLEAR;
      else if (tick)
         act = CNT_STEP;
      else
         act = CNT_HOLD;
      disarm = restart | empty | (tmo == '0);
   end
endmodule

// File: rtl/rx_stale_counter.sv
module rx_stale_counter
   import rx_stale_pkg::*;
#(
   parameter int CNT_W = 9
) (
   input  logic             clk,
   input  logic             rst,
   input  cnt_act_e         act,
   output logic [CNT_W-1:0] cnt_d
);
   localparam logic [CNT_W-1:0] CNT_MAX = {CNT_W{1'b1}};

   logic [CNT_W-1:0] cnt_q;

   always_comb begin
      unique case (act)
         CNT_CLEAR: cnt_d = '0;
         CNT_STEP:  cnt_d = (cnt_q == CNT_MAX) ? cnt_q : cnt_q + 1'b1;
         default:   cnt_d = cnt_q;
      endcase
   end

   always_ff @(posedge clk) begin
      if (rst)
         cnt_q <= '0;
      else
         cnt_q <= cnt_d;
   end
endmodule

// File: rtl/rx_stale_flag.sv
module rx_stale_flag #(
   parameter int TMO_W = 8,
   parameter int CNT_W = TMO_W + 1
) (
   input  logic             clk,
   input  logic             rst,
   input  logic             disarm,
   input  logic [CNT_W-1:0] cnt_d,
   input  logic [TMO_W-1:0] tmo,
   output logic             flag_q
);
   localparam int PAD_W = CNT_W - TMO_W;

   logic over;

   always_comb over = cnt_d > {{PAD_W{1'b0}}, tmo};

   always_ff @(posedge clk) begin
      if (rst)
         flag_q <= 1'b0;
      else if (disarm)
         flag_q <= 1'b0;
      else
         flag_q <= flag_q | over;
   end
endmodule

// File: rtl/rx_stale_timer.sv
module rx_stale_timer
   import rx_stale_pkg::*;
#(
   parameter int TMO_W   = 8,
   parameter int IRQ_REG = 0
) (
   input  logic             clk,
   input  logic             rst,
   input  logic             fifo_push,
   input  logic             fifo_pop,
   input  logic             fifo_empty,
   input  logic [TMO_W-1:0] tmo_value,
   input  logic             char_tick,
   input  logic             irq_en,
   output logic             stale_flag,
   output logic             stale_irq
);
   localparam int CNT_W = TMO_W + 1;

   if (TMO_W < 1 || TMO_W > 16) begin : g_bad_width
      $error("rx_stale_timer: TMO_W must lie in 1..16");
   end
   if (IRQ_REG != 0 && IRQ_REG != 1) begin : g_bad_irq
      $error("rx_stale_timer: IRQ_REG must be 0 or 1");
   end

   cnt_act_e         act;
   logic             disarm;
   logic [CNT_W-1:0] cnt_d;

   rx_stale_ctl #(.TMO_W(TMO_W)) u_ctl (
      .push   (fifo_push),
      .pop    (fifo_pop),
      .empty  (fifo_empty),
      .tick   (char_tick),
      .tmo    (tmo_value),
      .act    (act),
      .disarm (disarm)
   );

   rx_stale_counter #(.CNT_W(CNT_W)) u_cnt (
      .clk   (clk),
      .rst   (rst),
      .act   (act),
      .cnt_d (cnt_d)
   );

   rx_stale_flag #(.TMO_W(TMO_W), .CNT_W(CNT_W)) u_flag (
      .clk    (clk),
      .rst    (rst),
      .disarm (disarm),
      .cnt_d  (cnt_d),
      .tmo    (tmo_value),
      .flag_q (stale_flag)
   );

   if (IRQ_REG == 1) begin : g_irq_reg
      logic irq_q;
      always_ff @(posedge clk) begin
         if (rst)
            irq_q <= 1'b0;
         else
            irq_q <= stale_flag & irq_en;
      end
      assign stale_irq = irq_q;
   end else begin : g_irq_comb
      assign stale_irq = stale_flag & irq_en;
   end
endmodule

// File: rtl/rx_stale_timer_chk.sv
module rx_stale_timer_chk #(
   parameter int TMO_W   = 8,
   parameter int IRQ_REG = 0
) (
   input logic             clk,
   input logic             rst,
   input logic             fifo_push,
   input logic             fifo_pop,
   input logic             fifo_empty,
   input logic [TMO_W-1:0] tmo_value,
   input logic             char_tick,
   input logic             irq_en,
   input logic             stale_flag,
   input logic             stale_irq
);
   AST_POP_CLEARS: assert property (@(posedge clk) disable iff (rst)
      fifo_pop |=> !stale_flag); // R2
   AST_PUSH_CLEARS: assert property (@(posedge clk) disable iff (rst)
      fifo_push |=> !stale_flag); // R3
   AST_EMPTY_NO_FLAG: assert property (@(posedge clk) disable iff (rst)
      fifo_empty |=> !stale_flag); // R5
   AST_ZERO_DISABLES: assert property (@(posedge clk) disable iff (rst)
      (tmo_value == '0) |=> !stale_flag); // R6
   AST_FLAG_STICKY: assert property (@(posedge clk) disable iff (rst)
      (stale_flag && !fifo_push && !fifo_pop && !fifo_empty && tmo_value != '0)
      |=> stale_flag); // R8
   AST_RESET_CLEARS: assert property (@(posedge clk)
      rst |=> (!stale_flag && !stale_irq)); // R10

   if (IRQ_REG == 1) begin : g_chk_reg
      AST_IRQ_MASKED: assert property (@(posedge clk) disable iff (rst)
         !rst |=> (stale_irq == $past(stale_flag && irq_en))); // R7
   end else begin : g_chk_comb
      AST_IRQ_MASKED: assert property (@(posedge clk) disable iff (rst)
         stale_irq |-> (stale_flag && irq_en)); // R7
   end
endmodule

bind rx_stale_timer rx_stale_timer_chk #(.TMO_W(TMO_W), .IRQ_REG(IRQ_REG)) u_chk (
   .clk        (clk),
   .rst        (rst),
   .fifo_push  (fifo_push),
   .fifo_pop   (fifo_pop),
   .fifo_empty (fifo_empty),
   .tmo_value  (tmo_value),
   .char_tick  (char_tick),
   .irq_en     (irq_en),
   .stale_flag (stale_flag),
   .stale_irq  (stale_irq)
);

// File: tb/tb_rx_stale_timer.sv
module tb_rx_stale_timer;
   logic       clk = 1'b0;
   logic       rst = 1'b1;
   logic       fifo_push = 1'b0;
   logic       fifo_pop = 1'b0;
   logic       fifo_empty = 1'b1;
   logic [7:0] tmo_value = 8'd0;
   logic       char_tick = 1'b0;
   logic       irq_en = 1'b0;
   logic       stale_flag;
   logic       stale_irq;

   int total = 0;
   int bad = 0;
   int m_cnt = 0;
   bit m_flag = 1'b0;

   always #2 clk = ~clk;

   rx_stale_timer dut (
      .clk        (clk),
      .rst        (rst),
      .fifo_push  (fifo_push),
      .fifo_pop   (fifo_pop),
      .fifo_empty (fifo_empty),
      .tmo_value  (tmo_value),
      .char_tick  (char_tick),
      .irq_en     (irq_en),
      .stale_flag (stale_flag),
      .stale_irq  (stale_irq)
   );

   task automatic check(input string tag);
      total++;
      if (stale_flag !== m_flag) begin
         bad++;
         $display("FAIL %s flag: actual=%b expected=%b (limit=%0d count=%0d)",
                  tag, stale_flag, m_flag, tmo_value, m_cnt);
      end
      total++;
      if (stale_irq !== (m_flag & irq_en)) begin
         bad++;
         $display("FAIL R7 irq (%s): actual=%b expected=%b", tag, stale_irq,
                  m_flag & irq_en);
      end
   endtask

   // one clock: drive at negedge, reference update at posedge, sample after it
   task automatic step(input bit pu, input bit po, input bit em, input bit tk,
                       input string tag);
      @(negedge clk);
      fifo_push = pu; fifo_pop = po; fifo_empty = em; char_tick = tk;
      @(posedge clk);
      if (rst) begin
         m_cnt = 0; m_flag = 1'b0;
      end else if (pu || po || em) begin
         m_cnt = 0; m_flag = 1'b0;
      end else begin
         if (tk && m_cnt < 511) m_cnt++;
         m_flag = (tmo_value != 0) && (m_flag || m_cnt > int'(tmo_value));
      end
      #1;
      check(tag);
   endtask

   task automatic set_cfg(input int lim, input bit en);
      @(negedge clk);
      tmo_value = lim[7:0];
      irq_en = en;
   endtask

   task automatic sweep(input int lim, input bit en);
      string t1;
      t1 = (lim == 0) ? "R6" : "R1";
      set_cfg(lim, en);
      step(0, 0, 1, 0, "R5");
      step(1, 0, 0, 0, "R3");
      for (int k = 1; k <= lim + 3; k++) step(0, 0, 0, 1, t1);
      step(0, 0, 0, 0, "R8");
      step(0, 0, 0, 0, "R8");
      step(0, 1, 0, 0, "R2");
      for (int k = 1; k <= lim + 2; k++) step(0, 0, 0, 1, t1);
      step(1, 1, 0, 0, "R4");
      for (int k = 1; k <= lim + 2; k++) step(0, 0, 0, 1, t1);
      step(0, 0, 1, 1, "R5");
      step(0, 0, 1, 1, "R5");
   endtask

   initial begin
      #(4 * 200000);
      total++; bad++;
      $display("FAIL watchdog: actual=timeout expected=finish");
      $display("  test done: total=%0d bad=%0d", total, bad);
      $finish;
   end

   initial begin
      rst = 1'b1;
      step(0, 0, 1, 0, "R10");
      step(0, 0, 0, 1, "R10");
      @(negedge clk); rst = 1'b0;

      for (int en = 0; en < 2; en++) begin
         for (int lim = 0; lim <= 5; lim++) sweep(lim, en[0]);
         sweep(255, en[0]);
      end

      // R9: lowering the limit below the count sets the flag without a tick
      set_cfg(10, 1);
      step(1, 0, 0, 0, "R3");
      for (int k = 0; k < 4; k++) step(0, 0, 0, 1, "R1");
      set_cfg(2, 1);
      step(0, 0, 0, 0, "R9");
      // R8: raising the limit does not drop a set flag
      set_cfg(200, 1);
      step(0, 0, 0, 1, "R8");
      // R6: switching to zero clears it
      set_cfg(0, 1);
      step(0, 0, 0, 0, "R6");

      // R10: reset while flagged
      set_cfg(1, 1);
      step(1, 0, 0, 0, "R3");
      step(0, 0, 0, 1, "R1");
      step(0, 0, 0, 1, "R1");
      @(negedge clk); rst = 1'b1;
      step(0, 0, 0, 0, "R10");
      @(negedge clk); rst = 1'b0;
      step(0, 0, 0, 0, "R10");

      $display("  test done: total=%0d bad=%0d", total, bad);
      $finish;
   end
endmodule